// File: doc/BRIEF.md
# Wavetable PWM Player with DDS Pacing

The block plays a stored 8-bit waveform as the duty cycle of a single PWM pin. A 32-bit phase accumulator adds a tuning word on every clock. Each carry out of the accumulator steps a table pointer one place. The sample at the new pointer goes into a shadow compare register. At the end of each PWM period the active compare register takes the shadow value, so a pulse is never cut short or stretched in the middle of a period.

The PWM period is 255 clocks, so a sample value N gives N high clocks per period. The table can be 32 or 256 entries long, chosen by a mode input. A one-clock reference pulse marks each time the pointer wraps back to entry zero, which gives a trigger for viewing one waveform period. The table is loaded through a simple write port. Smoothing the PWM into an analog signal is done outside the block.

Top module: `wavePwmGen`

## Requirements
- R1: After reset the PWM counter, the table pointer and both compare registers are zero, so `pwmOut` and `wrapPulse` stay low until a non-zero sample has been fetched.
- R2: The PWM period is 255 clocks. `pwmOut` is high for the first C clocks of each period, where C is the active compare value. C=0 keeps the pin low and C=255 keeps it high.
- R3: A 32-bit accumulator adds `tuneWord` on every clock. Each carry out advances the table pointer by exactly one, so on average there are 2^32/`tuneWord` clocks between advances. A tuning word of zero freezes the pointer and the shadow sample.
- R4: With `longMode`=1 the pointer runs 0..255 and then returns to 0. With `longMode`=0 it runs 0..31 and then returns to 0. If the pointer is above 31 when short mode is selected, the next advance takes it to 0.
- R5: `wrapPulse` is high for exactly one clock, in the cycle after the advance that returns the pointer to 0. In steady state the pulses are therefore table-length × 2^32/`tuneWord` clocks apart.
- R6: On each advance the sample at the new pointer goes into the shadow register. The active compare changes only on the last count of a PWM period (count 254), and it then takes the newest sample, including one fetched in that same cycle. Rising edges of `pwmOut` therefore occur only at period starts.
- R7: When `wrEn` is high, `wrData` is written to table entry `wrAddr`. The new value appears on the output the next time that entry is fetched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tuneWord | input | 32 | Phase increment added on every clock |
| longMode | input | 1 | 1 selects the 256-entry table, 0 selects 32 entries |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | 8 | Table write address |
| wrData | input | 8 | Table write data |
| pwmOut | output | 1 | PWM output pin |
| wrapPulse | output | 1 | One-clock pulse when the table pointer wraps |

## Verification
Two functions can fall in the same cycle: a sample advance driven by the accumulator carry, and the end-of-period transfer into the active compare. The bench provokes this collision by running a ramp table with a tuning word that is not a power of two, so carries drift across every PWM phase. It then judges the output at the pins: every rising edge must fall a whole number of periods after the previous one, and every high pulse must have a width that belongs to the ramp. The bypass taken when the two coincide is checked next to the compare register by properties on the shadow and active values.

// File: rtl/wpgPkg.sv
package wpgPkg;
  parameter int SAMPLE_W = 8;

  typedef struct packed {
    logic                advance;    // one table step this cycle
    logic                periodEnd;  // last count of the PWM period
    logic [SAMPLE_W-1:0] pwmCount;   // current PWM count
  } wpgStrobes_t;
endpackage

// File: rtl/wpgCtrl.sv
module wpgCtrl
  import wpgPkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ACC_W-1:0] tuneWord,
  output wpgStrobes_t      strobes
);
  localparam logic [SAMPLE_W-1:0] CNT_LAST = SAMPLE_W'((1 << SAMPLE_W) - 2);

  logic [ACC_W-1:0]    phaseAcc;
  logic [ACC_W-1:0]    phaseSum;
  logic                phaseCarry;
  logic                ddsTick;
  logic [SAMPLE_W-1:0] pwmCnt;
  logic                lastCount;

  always_comb begin
    {phaseCarry, phaseSum} = {1'b0, phaseAcc} + {1'b0, tuneWord};
    lastCount = (pwmCnt == CNT_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseAcc <= '0;
      ddsTick  <= 1'b0;
      pwmCnt   <= '0;
    end else begin
      phaseAcc <= phaseSum;
      ddsTick  <= phaseCarry;
      pwmCnt   <= lastCount ? '0 : pwmCnt + 1'b1;
    end
  end

  assign strobes.advance   = ddsTick;
  assign strobes.periodEnd = lastCount;
  assign strobes.pwmCount  = pwmCnt;

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    pwmCnt <= CNT_LAST);
  p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    lastCount |=> pwmCnt == '0);
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lastCount |=> pwmCnt == $past(pwmCnt) + 1'b1);
  p_zero_tune_r3: assert property (@(posedge clk) disable iff (!rstN)
    tuneWord == '0 |=> !ddsTick);
endmodule

// File: rtl/wpgData.sv
module wpgData
  import wpgPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SHORT_LEN = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                longMode,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [SAMPLE_W-1:0] wrData,
  input  wpgStrobes_t         strobes,
  output logic                pwmOut,
  output logic                wrapPulse
);
  localparam int                DEPTH      = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LONG_LAST  = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] SHORT_LAST = ADDR_W'(SHORT_LEN - 1);

  logic [SAMPLE_W-1:0] waveMem [DEPTH];
  logic [ADDR_W-1:0]   rdAddr;
  logic [ADDR_W-1:0]   lastAddr;
  logic [ADDR_W-1:0]   nextAddr;
  logic                atEnd;
  logic [SAMPLE_W-1:0] fetchSample;
  logic [SAMPLE_W-1:0] shadowCmp;
  logic [SAMPLE_W-1:0] activeCmp;
  logic                wrapReg;

  always_ff @(posedge clk) begin
    if (wrEn) waveMem[wrAddr] <= wrData;
  end

  always_comb begin
    lastAddr    = longMode ? LONG_LAST : SHORT_LAST;
    atEnd       = (rdAddr >= lastAddr);
    nextAddr    = atEnd ? '0 : rdAddr + 1'b1;
    fetchSample = waveMem[nextAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddr    <= '0;
      shadowCmp <= '0;
      activeCmp <= '0;
      wrapReg   <= 1'b0;
    end else begin
      wrapReg <= strobes.advance && atEnd;
      if (strobes.advance) begin
        rdAddr    <= nextAddr;
        shadowCmp <= fetchSample;
      end
      if (strobes.periodEnd)
        activeCmp <= strobes.advance ? fetchSample : shadowCmp;
    end
  end

  assign pwmOut    = (strobes.pwmCount < activeCmp);
  assign wrapPulse = wrapReg;

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> $stable(rdAddr));
  p_addr_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && atEnd) |=> (rdAddr == '0));
  p_wrap_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrapReg |=> !wrapReg);
  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.periodEnd |=> $stable(activeCmp));
  p_active_newest_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.periodEnd |=> activeCmp == shadowCmp);
endmodule

// File: rtl/wavePwmGen.sv
module wavePwmGen
  import wpgPkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int SHORT_LEN = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ACC_W-1:0]    tuneWord,
  input  logic                longMode,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [SAMPLE_W-1:0] wrData,
  output logic                pwmOut,
  output logic                wrapPulse
);
  wpgStrobes_t strobes;

  wpgCtrl #(.ACC_W(ACC_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tuneWord (tuneWord),
    .strobes  (strobes)
  );

  wpgData #(.ADDR_W(ADDR_W), .SHORT_LEN(SHORT_LEN)) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .longMode  (longMode),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobes   (strobes),
    .pwmOut    (pwmOut),
    .wrapPulse (wrapPulse)
  );
endmodule

// File: tb/wavePwmGen_tb.sv
module wavePwmGen_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] tuneWord;
  logic        longMode;
  logic        wrEn;
  logic [7:0]  wrAddr;
  logic [7:0]  wrData;
  logic        pwmOut;
  logic        wrapPulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wavePwmGen dut_i (
    .clk(clk), .rstN(rstN), .tuneWord(tuneWord), .longMode(longMode),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut), .wrapPulse(wrapPulse)
  );

  localparam int NVEC = 7;
  localparam int DUTY_VEC [NVEC] = '{0, 1, 64, 128, 200, 254, 255};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fillTable(input int value);
    for (int i = 0; i < 256; i++) begin
      wrEn = 1'b1; wrAddr = 8'(i); wrData = 8'(value);
      @(negedge clk);
    end
    wrEn = 1'b0;
  endtask

  task automatic measureDuty(output int highs);
    highs = 0;
    for (int i = 0; i < 255; i++) begin
      @(negedge clk);
      if (pwmOut) highs++;
    end
  endtask

  // Cycles between two wrap pulses; also checks the pulse is one clock wide.
  task automatic wrapSpacing(input string req, output int spacing);
    int guard = 0;
    spacing = 0;
    while (!wrapPulse && guard < 5000) begin @(negedge clk); guard++; end
    @(negedge clk);
    check({req, " pulse width"}, int'(wrapPulse), 0);
    spacing = 1;
    while (!wrapPulse && spacing < 5000) begin @(negedge clk); spacing++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int duty;
    int sp;
    int lastRise;
    int riseCnt;
    int badRise;
    int badWidth;
    int highRun;
    int waitN;
    bit prev;
    rstN = 1'b0; tuneWord = '0; longMode = 1'b1;
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
    waitCycles(5);
    check("R1 pwmOut in reset", int'(pwmOut), 0);
    check("R1 wrapPulse in reset", int'(wrapPulse), 0);
    rstN = 1'b1;
    measureDuty(duty);
    check("R1 output low after reset", duty, 0);

    // Vector table: constant table, measured duty must equal sample value (R2, R7)
    tuneWord = 32'h8000_0000;
    for (int v = 0; v < NVEC; v++) begin
      fillTable(DUTY_VEC[v]);
      waitCycles(800);
      measureDuty(duty);
      check($sformatf("R2 duty for sample %0d", DUTY_VEC[v]), duty, DUTY_VEC[v]);
    end

    // R3: zero tuning word freezes the fetched sample; R7: rewrite then appears
    fillTable(100);
    waitCycles(800);
    tuneWord = '0;
    waitCycles(4);
    fillTable(30);
    waitCycles(800);
    measureDuty(duty);
    check("R3 frozen with zero tune", duty, 100);
    tuneWord = 32'h8000_0000;
    waitCycles(800);
    measureDuty(duty);
    check("R7 new table value reaches output", duty, 30);

    // R4/R5: wrap spacing = length * 2^32 / tune
    longMode = 1'b1; tuneWord = 32'h8000_0000;
    waitCycles(600);
    wrapSpacing("R5 long", sp);
    check("R4 long table wrap spacing", sp, 512);
    longMode = 1'b0;
    waitCycles(100);
    wrapSpacing("R5 short", sp);
    check("R4 short table wrap spacing", sp, 64);
    tuneWord = 32'h4000_0000;
    waitCycles(200);
    wrapSpacing("R5 quarter tune", sp);
    check("R5 spacing with quarter tune", sp, 128);

    // R4: switching to short mode with pointer above 31 wraps on next advance
    longMode = 1'b1; tuneWord = 32'h8000_0000;
    waitCycles(20);
    wrapSpacing("R5 pre-switch", sp);
    waitCycles(200);
    longMode = 1'b0;
    waitN = 0;
    while (!wrapPulse && waitN < 100) begin @(negedge clk); waitN++; end
    check("R4 prompt wrap after mode switch", int'(waitN <= 4), 1);

    // R6: ramp table, advances drifting across the PWM period
    for (int i = 0; i < 256; i++) begin
      wrEn = 1'b1; wrAddr = 8'(i); wrData = 8'((i % 32) * 8);
      @(negedge clk);
    end
    wrEn = 1'b0;
    longMode = 1'b0; tuneWord = 32'h0123_4567;
    waitCycles(600);
    lastRise = -1; riseCnt = 0; badRise = 0; badWidth = 0; highRun = 0;
    prev = pwmOut;
    for (int t = 0; t < 6000; t++) begin
      @(negedge clk);
      if (pwmOut && !prev) begin
        if (lastRise >= 0 && ((t - lastRise) % 255) != 0) badRise++;
        lastRise = t; riseCnt++; highRun = 0;
      end
      if (pwmOut) highRun++;
      if (!pwmOut && prev && (highRun % 8) != 0) badWidth++;
      prev = pwmOut;
    end
    check("R6 rising edges only at period start", badRise, 0);
    check("R6 pulse widths are table samples", badWidth, 0);
    check("R6 pulses observed", int'(riseCnt > 10), 1);

    summary();
  end
endmodule